// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit binary down-counters behind a byte-wide register interface. Two address bits pick counter 0, 1 or 2 for count writes and reads, and address 3 takes control words. A control word names a counter and either sets its byte access pattern and operating mode or freezes a snapshot of its count for a stable read. All counters advance on a shared one-cycle count-enable input `tick`. Each counter drives a level output and a one-cycle interrupt pulse.

Each channel pairs a byte-access unit with a counting engine. The access unit runs two state machines. The write pointer has the states WS_LO and WS_HI. The read state has four states: RS_LIVE_LO and RS_LIVE_HI read the live count, and RS_HOLD_LO and RS_HOLD_HI read the snapshot. Its transitions are: latch (LIVE_x to HOLD_x), byte step (LO to HI), wrap (HI to LIVE_LO), single-byte release (HOLD_x to LIVE_LO) and control reset (any state to LIVE_LO). The counting engine has the states CS_HALT and CS_RUN. A control word forces CS_HALT. A completed count write moves the engine to CS_RUN. Three modes are supported: interrupt on terminal count, rate generator and square wave.

Top module: `pit_timer`

## Requirements
- R1: After reset every counter is in CS_HALT with terminal-count mode and two-phase access. `cnt_out`, `irq` and `rdata` are all zero.
- R2: A control word at address 3 is decoded as follows. Bits 7:6 pick the counter (0 to 2). Bits 5:4 pick the access: 0 latch, 1 low byte only, 2 high byte only, 3 low then high. Bits 3:1 give the mode. Bit 0 (BCD) is ignored, so counting is always binary.
- R3: A non-latch control word does four things to its counter. It resets both byte pointers to the low byte and halts counting until a full count is written. It drives the output low for terminal-count behaviour and high for modes 2 and 3.
- R4: Count writes depend on the access setting. Low-only loads {0,byte} and high-only loads {byte,0}. Two-phase takes the low byte, then the high byte, loads on the second byte and wraps back to the low byte. The count register takes the value at the write edge, and the counter runs from there.
- R5: Terminal-count mode (mode 0) behaves as follows. After a load of N, the output stays low for N-1 ticks and rises on the Nth tick. It then stays high, and `irq` pulses for one cycle at that rise only.
- R6: Rate generator (mode 2) with count N behaves as follows. The output goes low on tick N-1. On tick N it returns high, the count reloads to N and `irq` pulses. This repeats every N ticks.
- R7: Square wave (mode 3) with count N behaves as follows. The output stays high for ceil(N/2) ticks, then low for floor(N/2) ticks. `irq` pulses each time the output returns high.
- R8: A count of 0 acts as 65536.
- R9: A latch command (access 0) copies the current count into the snapshot only when no snapshot is pending. A second latch command before the snapshot has been fully read is ignored.
- R10: A read at address 0 to 2 returns a byte in `rdata` one cycle later. `rdata` is zero after any cycle with no read. The byte comes from the snapshot while one is pending and otherwise from the live count. It is selected by the access setting: the low byte, the high byte, or in two-phase access the read pointer's byte. The snapshot is released after the last byte for that access setting has been read.
- R11: Mode values 6 and 7 behave as modes 2 and 3. Mode values 1, 4 and 5 behave as mode 0.
- R12: Counters change only on cycles with `tick` high. Without `tick` and without a write, outputs hold and `irq` stays low.
- R13: A control word with bits 7:6 equal to 3 (the read-back command) changes no counter, pointer or snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Common count enable, one decrement per high cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0 to 2 select a counter, 3 selects the control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| cnt_out | output | 3 | Counter output levels, one bit per counter |
| irq | output | 3 | One-cycle terminal-count pulses, one bit per counter |

## Verification
The bench reads a snapshot after extra ticks and after a repeated latch command. A design that re-captured the count on the second command, or kept the snapshot too long, would return the wrong bytes. It writes four bytes in two-phase access and a control word mid-count. A pointer that failed to wrap would load a garbage count, and a counter that kept running after reprogramming would show a moved count or a rising output. It measures the exact tick on which the output moves for mode 2, mode 3 with an odd count, the mode 6 and mode 1 aliases, a count of 0 (65536 ticks) and a set BCD bit. An off-by-one reload, half-period split or decode error would shift those edges by a tick. It issues a read-back command before a tick. A design that treated that command as a latch would return a stale byte.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        MD_TC     = 2'd0,
        MD_RATE   = 2'd1,
        MD_SQUARE = 2'd2
    } mode_t;

    typedef enum logic [1:0] {
        RS_LIVE_LO = 2'd0,
        RS_LIVE_HI = 2'd1,
        RS_HOLD_LO = 2'd2,
        RS_HOLD_HI = 2'd3
    } rd_state_t;

    typedef enum logic {
        WS_LO = 1'b0,
        WS_HI = 1'b1
    } wr_state_t;

    typedef enum logic {
        CS_HALT = 1'b0,
        CS_RUN  = 1'b1
    } cnt_state_t;

    function automatic mode_t decode_mode(input logic [2:0] field);
        mode_t m;
        case (field)
            3'd2, 3'd6: m = MD_RATE;
            3'd3, 3'd7: m = MD_SQUARE;
            default:    m = MD_TC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pit_access.sv
module pit_access
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  acc_t                  ctrl_acc,
    input  logic                  latch_cmd,
    input  logic                  data_wr,
    input  logic                  rd_req,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   live_cnt,
    output logic                  load,
    output logic [2*DATA_W-1:0]   load_val,
    output logic [DATA_W-1:0]     rd_byte
);
    localparam int CNT_W = 2 * DATA_W;

    acc_t               acc_q, acc_n;
    wr_state_t          ws_q, ws_n;
    rd_state_t          rs_q, rs_n;
    logic [DATA_W-1:0]  lo_q, lo_n;
    logic [CNT_W-1:0]   snap_q, snap_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_BOTH;
            ws_q   <= WS_LO;
            rs_q   <= RS_LIVE_LO;
            lo_q   <= '0;
            snap_q <= '0;
        end else begin
            acc_q  <= acc_n;
            ws_q   <= ws_n;
            rs_q   <= rs_n;
            lo_q   <= lo_n;
            snap_q <= snap_n;
        end
    end

    // next state: write pointer
    always_comb begin
        acc_n = acc_q;
        ws_n  = ws_q;
        lo_n  = lo_q;
        if (ctrl_wr) begin
            acc_n = ctrl_acc;
            ws_n  = WS_LO;
        end else if (data_wr && acc_q == ACC_BOTH) begin
            unique case (ws_q)
                WS_LO: begin
                    lo_n = wdata;
                    ws_n = WS_HI;
                end
                WS_HI: ws_n = WS_LO;
            endcase
        end
    end

    // next state: read pointer and snapshot
    always_comb begin
        rs_n   = rs_q;
        snap_n = snap_q;
        if (ctrl_wr) begin
            rs_n = RS_LIVE_LO;
        end else if (latch_cmd) begin
            unique case (rs_q)
                RS_LIVE_LO: begin rs_n = RS_HOLD_LO; snap_n = live_cnt; end
                RS_LIVE_HI: begin rs_n = RS_HOLD_HI; snap_n = live_cnt; end
                default:    rs_n = rs_q;
            endcase
        end else if (rd_req) begin
            if (acc_q == ACC_BOTH) begin
                unique case (rs_q)
                    RS_LIVE_LO: rs_n = RS_LIVE_HI;
                    RS_LIVE_HI: rs_n = RS_LIVE_LO;
                    RS_HOLD_LO: rs_n = RS_HOLD_HI;
                    RS_HOLD_HI: rs_n = RS_LIVE_LO;
                endcase
            end else begin
                unique case (rs_q)
                    RS_HOLD_LO, RS_HOLD_HI: rs_n = RS_LIVE_LO;
                    default:                rs_n = rs_q;
                endcase
            end
        end
    end

    // outputs: load strobe, load value, read byte
    always_comb begin
        logic [CNT_W-1:0] src;
        logic             pick_hi;
        load     = 1'b0;
        load_val = {lo_q, wdata};
        unique case (acc_q)
            ACC_LO: begin
                load     = data_wr;
                load_val = {{DATA_W{1'b0}}, wdata};
            end
            ACC_HI: begin
                load     = data_wr;
                load_val = {wdata, {DATA_W{1'b0}}};
            end
            ACC_BOTH: begin
                load     = data_wr && (ws_q == WS_HI);
                load_val = {wdata, lo_q};
            end
            default: load = 1'b0;
        endcase
        src     = (rs_q == RS_HOLD_LO || rs_q == RS_HOLD_HI) ? snap_q : live_cnt;
        pick_hi = (acc_q == ACC_HI) ||
                  (acc_q == ACC_BOTH && (rs_q == RS_LIVE_HI || rs_q == RS_HOLD_HI));
        rd_byte = pick_hi ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
    end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  mode_t            ctrl_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             cnt_out,
    output logic             irq
);
    localparam logic [CNT_W-1:0] HALF_MAX = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TWO      = {{(CNT_W-2){1'b0}}, 2'b10};

    cnt_state_t        st_q, st_n;
    mode_t             mode_q, mode_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, per_q, per_n;
    logic              out_q, out_n, irq_q, irq_n;

    // length of one half of a square-wave period; 0 stands for the full range
    function automatic logic [CNT_W-1:0] half_len(input logic [CNT_W-1:0] n,
                                                  input logic upper);
        logic [CNT_W-1:0] h;
        if (n == '0)
            h = HALF_MAX;
        else if (upper)
            h = {1'b0, n[CNT_W-1:1]} + {{(CNT_W-1){1'b0}}, n[0]};
        else
            h = {1'b0, n[CNT_W-1:1]};
        if (h == '0)
            h = ONE;
        return h;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_HALT;
            mode_q <= MD_TC;
            cnt_q  <= '0;
            per_q  <= '0;
            out_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            mode_q <= mode_n;
            cnt_q  <= cnt_n;
            per_q  <= per_n;
            out_q  <= out_n;
            irq_q  <= irq_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st_q;
        mode_n = mode_q;
        cnt_n  = cnt_q;
        per_n  = per_q;
        out_n  = out_q;
        irq_n  = 1'b0;
        if (ctrl_wr) begin
            st_n   = CS_HALT;
            mode_n = ctrl_mode;
            out_n  = (ctrl_mode != MD_TC);
        end else if (load) begin
            st_n  = CS_RUN;
            per_n = load_val;
            out_n = (mode_q != MD_TC);
            cnt_n = (mode_q == MD_SQUARE) ? half_len(load_val, 1'b1) : load_val;
        end else if (st_q == CS_RUN && tick) begin
            unique case (mode_q)
                MD_RATE: begin
                    if (cnt_q == ONE) begin
                        cnt_n = per_q;
                        out_n = 1'b1;
                        irq_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q - ONE;
                        if (cnt_q == TWO)
                            out_n = 1'b0;
                    end
                end
                MD_SQUARE: begin
                    if (cnt_q == ONE) begin
                        out_n = !out_q;
                        irq_n = !out_q;
                        cnt_n = half_len(per_q, !out_q);
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
                default: begin
                    cnt_n = cnt_q - ONE;
                    if (cnt_q == ONE && !out_q) begin
                        out_n = 1'b1;
                        irq_n = 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        count   = cnt_q;
        cnt_out = out_q;
        irq     = irq_q;
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [$clog2(NUM_CH+1)-1:0]   addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CH-1:0]             cnt_out,
    output logic [NUM_CH-1:0]             irq
);
    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam int CNT_W  = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic                          ctrl_hit;
    logic [1:0]                    sel_f;
    acc_t                          acc_f;
    mode_t                         mode_f;
    logic                          unused_bcd;
    logic [NUM_CH-1:0][DATA_W-1:0] rd_bytes;
    logic [DATA_W-1:0]             rd_mux;

    assign ctrl_hit   = wr_en && (addr == CTRL_ADDR);
    assign sel_f      = wdata[7:6];
    assign acc_f      = acc_t'(wdata[5:4]);
    assign mode_f     = decode_mode(wdata[3:1]);
    assign unused_bcd = wdata[0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             ch_ctrl, ch_latch, ch_load;
        logic [CNT_W-1:0] ch_load_val, ch_count;

        assign ch_ctrl  = ctrl_hit && (sel_f == 2'(g)) && (acc_f != ACC_LATCH);
        assign ch_latch = ctrl_hit && (sel_f == 2'(g)) && (acc_f == ACC_LATCH);

        pit_access #(.DATA_W(DATA_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (ch_ctrl),
            .ctrl_acc  (acc_f),
            .latch_cmd (ch_latch),
            .data_wr   (wr_en && (addr == ADDR_W'(g))),
            .rd_req    (rd_en && (addr == ADDR_W'(g))),
            .wdata     (wdata),
            .live_cnt  (ch_count),
            .load      (ch_load),
            .load_val  (ch_load_val),
            .rd_byte   (rd_bytes[g])
        );

        pit_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .ctrl_wr   (ch_ctrl),
            .ctrl_mode (mode_f),
            .load      (ch_load),
            .load_val  (ch_load_val),
            .count     (ch_count),
            .cnt_out   (cnt_out[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i))
                rd_mux = rd_bytes[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_mux : '0;
    end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [$clog2(NUM_CH+1)-1:0]   addr,
    input logic [DATA_W-1:0]             wdata,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_CH-1:0]             cnt_out,
    input logic [NUM_CH-1:0]             irq
);
    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic [2:0] unused_chk_bits;
    assign unused_chk_bits = {wdata[3], wdata[1], wdata[0]};

    // R10: no read, no data
    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

    // R12: nothing moves without a tick or a write
    p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(cnt_out) && irq == '0));

    // R12: interrupts follow a tick
    p_irq_after_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> $past(tick));

    // R13: read-back command leaves outputs alone
    p_readback_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR && wdata[7:6] == 2'd3 && !tick) |=> $stable(cnt_out));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5: every interrupt coincides with a high output
        p_irq_out_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> cnt_out[g]);

        // R3: control word sets the output level from the mode
        p_ctrl_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CTRL_ADDR && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0)
            |=> cnt_out[g] == $past(wdata[2]));
    end

endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] cnt_out;
    logic [2:0] irq;

    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  rd_seen = 1'b0;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_out(cnt_out), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            int    e;
            string t;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected read actual=%0h expected=none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata != e[7:0]) begin
                    n_fail++;
                    $display("FAIL %s read actual=%0h expected=%0h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt_out", cnt_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rdata", rdata, 0);

        // R4/R5: channel 0, two-phase, mode 0, count 5
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h05);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd0, 8'h05, "R4 two-phase low");
        bus_rd(2'd0, 8'h00, "R10 two-phase high");
        ticks(4);
        chk("R5 out low before tc", cnt_out[0], 0);
        chk("R12 halted channels idle", cnt_out[2:1], 0);
        ticks(1);
        chk("R5 out high at tc", cnt_out[0], 1);
        chk("R5 irq at tc", irq[0], 1);
        @(negedge clk);
        chk("R5 irq one cycle", irq[0], 0);

        // R9: latch on channel 1
        bus_wr(2'd3, 8'h70);
        bus_wr(2'd1, 8'h34);
        bus_wr(2'd1, 8'h12);
        ticks(4);
        bus_wr(2'd3, 8'h40);
        ticks(3);
        bus_wr(2'd3, 8'h40);
        bus_rd(2'd1, 8'h30, "R9 snapshot low");
        bus_rd(2'd1, 8'h12, "R9 snapshot high");
        bus_rd(2'd1, 8'h2D, "R10 live low after release");
        bus_rd(2'd1, 8'h12, "R10 live high after release");

        // R6: channel 2, low only, mode 2, count 4
        bus_wr(2'd3, 8'h94);
        chk("R3 mode 2 out high", cnt_out[2], 1);
        bus_wr(2'd2, 8'h04);
        bus_rd(2'd2, 8'h04, "R4 low-only read");
        bus_rd(2'd2, 8'h04, "R10 low-only repeat");
        ticks(3);
        chk("R6 out low", cnt_out[2], 0);
        ticks(1);
        chk("R6 out high on reload", cnt_out[2], 1);
        chk("R6 irq on reload", irq[2], 1);
        ticks(3);
        chk("R6 second period low", cnt_out[2], 0);
        ticks(1);
        chk("R6 second period high", cnt_out[2], 1);
        bus_wr(2'd3, 8'h80);
        ticks(2);
        bus_rd(2'd2, 8'h04, "R10 single-byte snapshot");
        bus_rd(2'd2, 8'h02, "R10 single-byte release");

        // R4: channel 0, high only
        bus_wr(2'd3, 8'h20);
        chk("R3 mode 0 out low", cnt_out[0], 0);
        bus_wr(2'd0, 8'h01);
        bus_rd(2'd0, 8'h01, "R4 high-only load");
        ticks(1);
        bus_rd(2'd0, 8'h00, "R10 high-only read");

        // R7: channel 1, low only, mode 3, count 5
        bus_wr(2'd3, 8'h56);
        chk("R3 mode 3 out high", cnt_out[1], 1);
        bus_wr(2'd1, 8'h05);
        ticks(2);
        chk("R7 high half", cnt_out[1], 1);
        ticks(1);
        chk("R7 low after ceil half", cnt_out[1], 0);
        ticks(1);
        chk("R7 still low", cnt_out[1], 0);
        ticks(1);
        chk("R7 high after floor half", cnt_out[1], 1);
        chk("R7 irq on rise", irq[1], 1);
        ticks(3);
        chk("R7 next low", cnt_out[1], 0);

        // R11: mode 6 on channel 2, count 3
        bus_wr(2'd3, 8'h9C);
        bus_wr(2'd2, 8'h03);
        ticks(2);
        chk("R11 mode 6 low", cnt_out[2], 0);
        ticks(1);
        chk("R11 mode 6 reload high", cnt_out[2], 1);
        chk("R11 mode 6 irq", irq[2], 1);

        // R13: read-back command does not latch
        bus_wr(2'd3, 8'hC0);
        ticks(1);
        bus_rd(2'd2, 8'h02, "R13 read-back ignored");

        // R3/R4: pointer wrap, halt on control word
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h10);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd0, 8'h00);
        ticks(1);
        bus_wr(2'd3, 8'h30);
        chk("R3 out low after control", cnt_out[0], 0);
        ticks(5);
        chk("R3 halted no tc", cnt_out[0], 0);
        bus_rd(2'd0, 8'h02, "R3 halted count low");
        bus_rd(2'd0, 8'h00, "R3 halted count high");
        bus_wr(2'd0, 8'h02);
        bus_wr(2'd0, 8'h00);
        ticks(1);
        chk("R3 restart low", cnt_out[0], 0);
        ticks(1);
        chk("R3 restart tc", cnt_out[0], 1);

        // R11: mode 1 behaves as mode 0
        bus_wr(2'd3, 8'h92);
        chk("R11 mode 1 out low", cnt_out[2], 0);
        bus_wr(2'd2, 8'h02);
        ticks(2);
        chk("R11 mode 1 tc", cnt_out[2], 1);

        // R2: BCD bit ignored
        bus_wr(2'd3, 8'h31);
        bus_wr(2'd0, 8'h10);
        bus_wr(2'd0, 8'h00);
        ticks(10);
        bus_rd(2'd0, 8'h06, "R2 binary with bcd bit low");
        bus_rd(2'd0, 8'h00, "R2 binary with bcd bit high");

        // R8: zero count is 65536
        bus_wr(2'd3, 8'h70);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd1, 8'h00);
        ticks(65535);
        chk("R8 low before 65536", cnt_out[1], 0);
        ticks(1);
        chk("R8 high at 65536", cnt_out[1], 1);
        chk("R8 irq at 65536", irq[1], 1);

        repeat (3) @(negedge clk);
        chk("R10 all reads answered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule